// File: doc/BRIEF.md
# Comparator edge interrupt controller

This block watches the digital outputs of four analog comparators and turns selected transitions into interrupt requests. Each comparator output is brought into the clock domain through a two-stage synchronizer. It is then optionally inverted and passed to a small per-channel edge tracker that decides whether a rising transition, a falling transition or both count as events. A qualifying event latches a sticky pending flag. The channel's interrupt request is that flag gated by the channel's interrupt enable.

Software reaches the block over a plain synchronous register bus: an address, a write strobe with write data, and registered read data. Address 0 holds the edge mode register, with one 2-bit field per channel. Addresses 1 to 4 hold one control and status register for each channel, 0 to 3. Each of these registers carries the channel enable, interrupt enable, polarity select, pending flag and a read-only live level.

The edge tracker in each channel is a three-state machine. OFF is the state while the channel is disabled. SEEN_LOW and SEEN_HIGH hold the last accepted level while the channel is enabled. Its transitions are:
- OFF to SEEN_LOW or SEEN_HIGH when the channel is enabled, following the present level and reporting no event.
- SEEN_LOW to SEEN_HIGH on a rise.
- SEEN_HIGH to SEEN_LOW on a fall.
- Either armed state back to OFF when the channel is disabled.

Top module: `cmpirq_top`

## Requirements
- R1: Each comparator input passes through two synchronizing flops. An input change applied before clock edge k can set the pending flag and raise the interrupt no earlier than after edge k+2, and does so after that edge.
- R2: The mode register sits at address 0 and resets to 0xFF. Channel n uses bits 2n+1:2n, so channel 3 is in bits 7:6 and channel 0 in bits 1:0. A write stores the value and reads return it.
- R3: Mode code 01 sets pending on a falling edge only. Code 10 sets it on a rising edge only. Code 11 sets it on both edges.
- R4: Mode code 00 never sets the pending flag, whatever edges occur.
- R5: The control register of channel n sits at address n+1 and resets to 0x02. Its bits are: bit 0 channel enable, bit 1 interrupt enable, bit 2 polarity select, bit 3 pending, bit 4 live status (read-only). Bits 7:5 read 0.
- R6: When polarity select is 1, the synchronized input is inverted before edge detection and before the status bit. When it is 0, the input passes through unchanged.
- R7: While the channel is enabled, the status bit reads the synchronized, polarity-adjusted level (1 means the negative input is below the positive input). While the channel is disabled it reads 0.
- R8: The pending flag is sticky. Writing 0 to bit 3 clears it and writing 1 leaves it unchanged.
- R9: If a qualifying edge arrives in the same cycle as a write that clears the pending flag, the flag ends up set.
- R10: The interrupt request of a channel is high exactly when its pending flag and its interrupt enable are both 1.
- R11: A disabled channel never sets pending. Enabling a channel whose input level differs from its level before disabling produces no event.
- R12: Read data is registered: bus_rdata shows the register selected by bus_addr one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 4 | Raw comparator outputs, one bit per channel |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 4 | Interrupt request per channel |

## Verification
After an input change is driven between edges, the pending flag and interrupt request are due after the third rising edge. The bench checks that the interrupt is still low after the second edge and high after the third when the edge qualifies. Register writes take effect at the edge that samples the strobe. Read data appears one edge after the address is presented, so every read waits exactly that edge and samples at the following falling edge. The clear-versus-set case places the clearing write on the same edge that completes the three-edge input path.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

    typedef enum logic [1:0] {
        TRK_OFF       = 2'b00,
        TRK_SEEN_LOW  = 2'b01,
        TRK_SEEN_HIGH = 2'b10
    } trk_state_t;

    localparam int EN_BIT   = 0;
    localparam int IE_BIT   = 1;
    localparam int POL_BIT  = 2;
    localparam int PEND_BIT = 3;
    localparam int STAT_BIT = 4;

    localparam int MODE_FALL_BIT = 0;
    localparam int MODE_RISE_BIT = 1;

endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/cmpirq_edge_fsm.sv
module cmpirq_edge_fsm
    import cmpirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       level,
    input  logic [1:0] mode,
    output logic       hit
);
    trk_state_t state_q;
    trk_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_OFF: begin
                if (enable) state_d = level ? TRK_SEEN_HIGH : TRK_SEEN_LOW;
            end
            TRK_SEEN_LOW: begin
                if (!enable)    state_d = TRK_OFF;
                else if (level) state_d = TRK_SEEN_HIGH;
            end
            TRK_SEEN_HIGH: begin
                if (!enable)     state_d = TRK_OFF;
                else if (!level) state_d = TRK_SEEN_LOW;
            end
            default: state_d = TRK_OFF;
        endcase
    end

    // qualified event output
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            TRK_OFF:       hit = 1'b0;
            TRK_SEEN_LOW:  hit = enable && level && mode[MODE_RISE_BIT];
            TRK_SEEN_HIGH: hit = enable && !level && mode[MODE_FALL_BIT];
            default:       hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmpirq_chan.sv
module cmpirq_chan
    import cmpirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [PEND_BIT:0] wr_bits,
    input  logic              sync_level,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] rd_val,
    output logic              en_o,
    output logic              ie_o,
    output logic              pend_o,
    output logic              irq_o
);
    logic en_q, ie_q, pol_q, pend_q;
    logic level;
    logic hit;
    logic clear_req;

    assign level = sync_level ^ pol_q;

    cmpirq_edge_fsm u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (en_q),
        .level  (level),
        .mode   (mode),
        .hit    (hit)
    );

    assign clear_req = wr_sel && !wr_bits[PEND_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b1;
            pol_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr_sel) begin
                en_q  <= wr_bits[EN_BIT];
                ie_q  <= wr_bits[IE_BIT];
                pol_q <= wr_bits[POL_BIT];
            end
            // a new event overrides a simultaneous clear
            pend_q <= hit || (pend_q && !clear_req);
        end
    end

    always_comb begin
        rd_val           = '0;
        rd_val[EN_BIT]   = en_q;
        rd_val[IE_BIT]   = ie_q;
        rd_val[POL_BIT]  = pol_q;
        rd_val[PEND_BIT] = pend_q;
        rd_val[STAT_BIT] = en_q && level;
    end

    assign en_o   = en_q;
    assign ie_o   = ie_q;
    assign pend_o = pend_q;
    assign irq_o  = pend_q && ie_q;
endmodule

// File: rtl/cmpirq_top.sv
module cmpirq_top
    import cmpirq_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   cmp_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   irq
);
    localparam int MODE_W = 2 * N_CH;

    logic [MODE_W-1:0] mode_q;
    logic [N_CH-1:0]   cmp_sync;
    logic [N_CH-1:0]   ch_en, ch_ie, ch_pend;
    logic [DATA_W-1:0] ch_rd [N_CH];
    logic [DATA_W-1:0] rd_mux;

    cmpirq_sync #(.WIDTH(N_CH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_in),
        .sync_out (cmp_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '1;
        else if (bus_wr && bus_addr == '0)
            mode_q <= bus_wdata[MODE_W-1:0];
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic sel;
        assign sel = bus_wr && (bus_addr == ADDR_W'(i + 1));

        cmpirq_chan #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (sel),
            .wr_bits    (bus_wdata[PEND_BIT:0]),
            .sync_level (cmp_sync[i]),
            .mode       (mode_q[2*i +: 2]),
            .rd_val     (ch_rd[i]),
            .en_o       (ch_en[i]),
            .ie_o       (ch_ie[i]),
            .pend_o     (ch_pend[i]),
            .irq_o      (irq[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == '0) rd_mux = DATA_W'(mode_q);
        for (int i = 0; i < N_CH; i++) begin
            if (bus_addr == ADDR_W'(i + 1)) rd_mux = ch_rd[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/cmpirq_checker.sv
module cmpirq_checker #(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [2*N_CH-1:0]   mode_q,
    input logic [N_CH-1:0]     ch_en,
    input logic [N_CH-1:0]     ch_ie,
    input logic [N_CH-1:0]     ch_pend,
    input logic [N_CH-1:0]     irq
);
    // R2: a mode write is stored
    a_r2_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0) |=> (mode_q == $past(bus_wdata[2*N_CH-1:0])));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        // R4: invalid mode never sets pending
        a_r4_invalid_no_set: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b00 && !ch_pend[i]) |=> !ch_pend[i]);

        // R11: a disabled channel never sets pending
        a_r11_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && !ch_pend[i]) |=> !ch_pend[i]);

        // R8: pending stays set unless a clearing write hits it
        a_r8_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_pend[i] && !(bus_wr && bus_addr == ADDR_W'(i + 1) && !bus_wdata[3]))
            |=> ch_pend[i]);

        // R10: a request only rises with its flag or its enable
        a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> ($rose(ch_pend[i]) || $rose(ch_ie[i])));
    end
endmodule

bind cmpirq_top cmpirq_checker #(
    .N_CH   (N_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mode_q    (mode_q),
    .ch_en     (ch_en),
    .ch_ie     (ch_ie),
    .ch_pend   (ch_pend),
    .irq       (irq)
);

// File: tb/cmpirq_top_test.sv
`timescale 1ns/1ps
module cmpirq_top_test;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [N-1:0] cmp_in;
    logic [2:0] addr;
    logic       wr;
    logic [7:0] wdata;
    wire  [7:0] rdata;
    wire  [N-1:0] irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    cmpirq_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_in    (cmp_in),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        rst_n = 1'b0; cmp_in = '0; addr = '0; wr = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk("R10 irq after reset", 8'(irq), 8'h00);
        rd_reg(3'd0, rv); chk("R2 R12 mode reset", rv, 8'hFF);
        for (int c = 0; c < N; c++) begin
            rd_reg(3'(c + 1), rv); chk("R5 ctrl reset", rv, 8'h02);
        end

        // sweep: channel x mode x polarity x new raw level
        for (int c = 0; c < N; c++) begin
            for (int m = 0; m < 4; m++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int d = 0; d < 2; d++) begin
                        logic [7:0] mode_v;
                        logic       eff;
                        logic       exp;
                        eff = 1'(d ^ p);
                        exp = eff ? 1'(m >> 1) : 1'(m & 1);
                        wr_reg(3'(c + 1), 8'h02 | 8'(p << 2));
                        cmp_in[c] = ~1'(d);
                        idle(4);
                        mode_v = (8'hFF & ~(8'h03 << (2 * c))) | 8'(m << (2 * c));
                        wr_reg(3'd0, mode_v);
                        wr_reg(3'(c + 1), 8'h0B | 8'(p << 2));
                        idle(3);
                        chk("R11 no event on enable", 8'(irq[c]), 8'h00);
                        cmp_in[c] = 1'(d);
                        idle(2);
                        chk("R1 not before third edge", 8'(irq[c]), 8'h00);
                        idle(1);
                        chk("R1 R3 R4 R6 R10 irq after edge", 8'(irq[c]), 8'(exp));
                        rd_reg(3'(c + 1), rv);
                        chk("R3 R4 pending bit", 8'(rv[3]), 8'(exp));
                        chk("R6 R7 status bit", 8'(rv[4]), 8'(eff));
                        chk("R5 ctrl readback",
                            rv, 8'h03 | 8'(p << 2) | 8'(exp << 3) | 8'(eff << 4));
                        wr_reg(3'(c + 1), 8'h02);
                    end
                end
            end
        end

        // R2 field write and readback
        wr_reg(3'd0, 8'h1B);
        rd_reg(3'd0, rv); chk("R2 mode readback", rv, 8'h1B);
        wr_reg(3'd0, 8'hFF);

        // R10 interrupt enable gating on channel 0
        cmp_in[0] = 1'b0;
        idle(4);
        wr_reg(3'd1, 8'h01);
        idle(3);
        cmp_in[0] = 1'b1;
        idle(3);
        chk("R10 gated by ie", 8'(irq[0]), 8'h00);
        rd_reg(3'd1, rv); chk("R10 pending while gated", 8'(rv[3]), 8'h01);
        wr_reg(3'd1, 8'h0B);
        chk("R10 irq after ie set", 8'(irq[0]), 8'h01);

        // R8 write 0 clears, write 1 has no effect
        wr_reg(3'd1, 8'h03);
        chk("R8 clear by write 0", 8'(irq[0]), 8'h00);
        wr_reg(3'd1, 8'h0B);
        rd_reg(3'd1, rv); chk("R8 write 1 no set", 8'(rv[3]), 8'h00);

        // R9 set beats clear in the same cycle
        cmp_in[0] = 1'b0;
        idle(3);
        chk("R9 setup pending", 8'(irq[0]), 8'h01);
        cmp_in[0] = 1'b1;
        idle(2);
        addr = 3'd1; wdata = 8'h03; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        chk("R9 set wins over clear", 8'(irq[0]), 8'h01);
        wr_reg(3'd1, 8'h03);
        chk("R9 clear alone", 8'(irq[0]), 8'h00);

        // R7 R11 disabled channel: no status, no pending, clean re-enable
        wr_reg(3'd1, 8'h02);
        cmp_in[0] = 1'b0; idle(4);
        cmp_in[0] = 1'b1; idle(4);
        cmp_in[0] = 1'b0; idle(4);
        cmp_in[0] = 1'b1; idle(4);
        rd_reg(3'd1, rv); chk("R7 R11 disabled reads", rv, 8'h02);
        wr_reg(3'd1, 8'h07);
        idle(4);
        chk("R11 irq after re-enable", 8'(irq[0]), 8'h00);
        rd_reg(3'd1, rv); chk("R6 R11 re-enable inverted", rv, 8'h07);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule